// File: doc/BRIEF.md
# Multi-channel edge input capture

This block timestamps events on external pins. Four independent channels share one free-running counter value that comes from outside the block. Each channel watches one asynchronous input pin and passes it through a synchroniser. When the synchronised level shows the edge that the channel's select field asks for, the channel copies the current counter value into its own capture register and sets its event flag.

Each channel has its own interrupt enable. A channel drives its interrupt line whenever its flag is set and its enable is high. Software clears the flag by pulsing the channel's clear input with a 1.

If a second qualifying edge arrives before the flag is cleared, the capture register takes the newer timestamp and the channel's overrun bit is set. Software can then tell that one timestamp was lost.

Top module: `edge_capture_unit`

## Requirements
- R1: While reset is high and in the cycle after it, every capture register, event flag, overrun bit and interrupt line reads 0.
- R2: Every pin passes through a two-flop synchroniser before edge detection. A pin change first sampled at rising clock edge k is captured at edge k+2: the capture register then holds the counter value sampled at edge k+2, and the flag reads 1 after that edge.
- R3: Select code 01 (rising) captures only on a 0-to-1 pin transition. A 1-to-0 transition leaves the capture register and the overrun bit unchanged.
- R4: Select code 10 (falling) captures only on a 1-to-0 transition. A 0-to-1 transition sets no flag.
- R5: Select code 11 (both) captures on every transition in either direction.
- R6: Select code 00 (disabled) never captures and never sets the flag, whatever the pin does.
- R7: A set flag stays set until a 1 is applied to the channel's clear input. The flag reads 0 after the edge at which that clear is sampled, unless a new event arrives at that same edge.
- R8: When a qualifying event and a clear are sampled at the same edge, the flag stays 1 and the capture register takes the new timestamp.
- R9: A qualifying event while the flag is already set, with no clear at that edge, overwrites the capture register and sets the overrun bit. The overrun bit stays set until a clear is sampled; a clear always drops it, even when an event arrives at the same edge.
- R10: A channel's interrupt line is high exactly when its flag is set and its enable bit is 1. With the enable at 0, the flag still sets but the interrupt line stays low.
- R11: Channels act independently. Events on several channels at the same edge each capture the same counter value and each set their own flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cnt_i | input | CNT_W (16) | Shared free-running counter value |
| pin_i | input | NUM_CH (4) | Asynchronous event pins, one per channel |
| edge_sel_i | input | 2*NUM_CH (8) | Edge select, 2 bits per channel (channel c at bits 2c+1:2c): 00 off, 01 rising, 10 falling, 11 both |
| irq_en_i | input | NUM_CH (4) | Per-channel interrupt enable |
| flag_clr_i | input | NUM_CH (4) | Per-channel flag clear; 1 clears |
| cap_val_o | output | NUM_CH*CNT_W (64) | Capture registers; channel c at bits 16c+15:16c |
| flag_o | output | NUM_CH (4) | Per-channel event flags |
| ovr_o | output | NUM_CH (4) | Per-channel overrun bits |
| irq_o | output | NUM_CH (4) | Per-channel interrupt lines |

## Verification
The assertions check several rules on every cycle:
- a disabled channel never reports an event, and a directional select only fires at the matching pin level;
- every event loads the counter value and sets the flag;
- a cycle without an event leaves the capture register untouched;
- the flag and the overrun bit hold until a clear arrives;
- an event on a set flag raises overrun.

Only the bench scenarios can show the rest: the exact two-cycle latency from pin to timestamp, an edge landing in the same cycle as a clear, simultaneous events on several channels, and the interrupt line staying low while the flag is set with the enable at 0.

// File: rtl/cap_pkg.sv
package cap_pkg;

    localparam int SEL_W = 2;

    typedef enum logic [SEL_W-1:0] {
        EDGE_OFF  = 2'b00,
        EDGE_RISE = 2'b01,
        EDGE_FALL = 2'b10,
        EDGE_BOTH = 2'b11
    } edge_sel_e;

    typedef struct packed {
        logic rise;
        logic fall;
    } edge_ev_t;

    function automatic logic sel_hit(edge_sel_e sel, edge_ev_t ev);
        logic hit;
        case (sel)
            EDGE_RISE: hit = ev.rise;
            EDGE_FALL: hit = ev.fall;
            EDGE_BOTH: hit = ev.rise | ev.fall;
            default:   hit = 1'b0;
        endcase
        return hit;
    endfunction

endpackage

// File: rtl/cap_sync.sv
module cap_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic pin,
    output logic level,
    output logic prev
);
    // stages [0..STAGES-1] synchronise, stage STAGES remembers the last level
    logic [STAGES:0] sh;

    always_ff @(posedge clk) begin
        if (rst) begin
            sh <= '0;
        end else begin
            sh <= {sh[STAGES-1:0], pin};
        end
    end

    assign level = sh[STAGES-1];
    assign prev  = sh[STAGES];
endmodule

// File: rtl/cap_edge.sv
module cap_edge
    import cap_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      level,
    input  logic      prev,
    input  edge_sel_e sel,
    output logic      evt
);
    edge_ev_t ev;

    always_comb begin
        ev.rise = level & ~prev;
        ev.fall = ~level & prev;
        evt     = sel_hit(sel, ev);
    end

    assert_off_quiet_R6: assert property (@(posedge clk) disable iff (rst)
        (sel == EDGE_OFF) |-> !evt);
    assert_rise_level_R3: assert property (@(posedge clk) disable iff (rst)
        (evt && sel == EDGE_RISE) |-> (level && !prev));
    assert_fall_level_R4: assert property (@(posedge clk) disable iff (rst)
        (evt && sel == EDGE_FALL) |-> (!level && prev));
    assert_evt_change_R5: assert property (@(posedge clk) disable iff (rst)
        evt |-> (level != prev));
endmodule

// File: rtl/cap_chan.sv
module cap_chan #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             evt,
    input  logic [CNT_W-1:0] cnt,
    input  logic             clr,
    input  logic             en,
    output logic [CNT_W-1:0] cap,
    output logic             flag,
    output logic             ovr,
    output logic             irq
);
    typedef struct packed {
        logic [CNT_W-1:0] cap;
        logic             flag;
        logic             ovr;
    } chan_state_t;

    chan_state_t st, nx;

    always_comb begin
        nx = st;
        if (evt) begin
            nx.cap = cnt;
        end
        // a fresh event outranks a clear for the flag
        nx.flag = evt | (st.flag & ~clr);
        if (clr) begin
            nx.ovr = 1'b0;
        end else if (evt && st.flag) begin
            nx.ovr = 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            st <= '0;
        end else begin
            st <= nx;
        end
    end

    assign cap  = st.cap;
    assign flag = st.flag;
    assign ovr  = st.ovr;
    assign irq  = st.flag & en;

    assert_capture_R2: assert property (@(posedge clk) disable iff (rst)
        evt |=> (cap == $past(cnt)) && flag);
    assert_cap_hold_R6: assert property (@(posedge clk) disable iff (rst)
        !evt |=> $stable(cap));
    assert_flag_hold_R7: assert property (@(posedge clk) disable iff (rst)
        (flag && !clr) |=> flag);
    assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
        (clr && !evt) |=> !flag);
    assert_clr_race_R8: assert property (@(posedge clk) disable iff (rst)
        (clr && evt) |=> flag);
    assert_overrun_R9: assert property (@(posedge clk) disable iff (rst)
        (evt && flag && !clr) |=> ovr);
    assert_ovr_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (ovr && !clr) |=> ovr);
endmodule

// File: rtl/edge_capture_unit.sv
module edge_capture_unit
    import cap_pkg::*;
#(
    parameter int NUM_CH      = 4,
    parameter int CNT_W       = 16,
    parameter int SYNC_STAGES = 2
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic [CNT_W-1:0]        cnt_i,
    input  logic [NUM_CH-1:0]       pin_i,
    input  logic [SEL_W*NUM_CH-1:0] edge_sel_i,
    input  logic [NUM_CH-1:0]       irq_en_i,
    input  logic [NUM_CH-1:0]       flag_clr_i,
    output logic [NUM_CH*CNT_W-1:0] cap_val_o,
    output logic [NUM_CH-1:0]       flag_o,
    output logic [NUM_CH-1:0]       ovr_o,
    output logic [NUM_CH-1:0]       irq_o
);
    for (genvar c = 0; c < NUM_CH; c++) begin : g_ch
        logic      level, prev, evt;
        edge_sel_e sel;

        assign sel = edge_sel_e'(edge_sel_i[SEL_W*c +: SEL_W]);

        cap_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk   (clk),
            .rst   (rst),
            .pin   (pin_i[c]),
            .level (level),
            .prev  (prev)
        );

        cap_edge u_edge (
            .clk   (clk),
            .rst   (rst),
            .level (level),
            .prev  (prev),
            .sel   (sel),
            .evt   (evt)
        );

        cap_chan #(.CNT_W(CNT_W)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .evt  (evt),
            .cnt  (cnt_i),
            .clr  (flag_clr_i[c]),
            .en   (irq_en_i[c]),
            .cap  (cap_val_o[CNT_W*c +: CNT_W]),
            .flag (flag_o[c]),
            .ovr  (ovr_o[c]),
            .irq  (irq_o[c])
        );
    end

    assert_irq_gate_R10: assert property (@(posedge clk) disable iff (rst)
        (irq_o & ~flag_o) == '0);
endmodule

// File: tb/test_edge_capture_unit.sv
module test_edge_capture_unit;
    localparam int NCH = 4;
    localparam int CW  = 16;

    logic clk = 1'b0;
    logic rst = 1'b1;
    always #2 clk = ~clk;

    logic [CW-1:0]     cnt = '0;
    always @(posedge clk) cnt <= cnt + 1'b1;

    logic [NCH-1:0]    pin = '0, en = '0, clr = '0;
    logic [2*NCH-1:0]  sel = '0;
    logic [NCH*CW-1:0] cap_val;
    logic [NCH-1:0]    flag, ovr, irq;

    edge_capture_unit i_edge_capture_unit (
        .clk(clk), .rst(rst), .cnt_i(cnt), .pin_i(pin), .edge_sel_i(sel),
        .irq_en_i(en), .flag_clr_i(clr), .cap_val_o(cap_val),
        .flag_o(flag), .ovr_o(ovr), .irq_o(irq)
    );

    int checks = 0;
    int fails  = 0;
    logic [CW-1:0] exp_q [NCH][$];
    logic [CW-1:0] last_cap [NCH];

    function automatic logic [CW-1:0] cap_of(int ch);
        return cap_val[ch*CW +: CW];
    endfunction

    task automatic chk(string req, logic [63:0] act, logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // monitor: every change of a capture register must match the next expected stamp
    initial for (int c = 0; c < NCH; c++) last_cap[c] = '0;
    always @(negedge clk) begin
        if (!rst) begin
            for (int c = 0; c < NCH; c++) begin
                if (cap_of(c) !== last_cap[c]) begin
                    checks++;
                    if (exp_q[c].size() == 0) begin
                        fails++;
                        $display("FAIL R2 ch%0d unexpected capture: actual=%0h expected=none", c, cap_of(c));
                    end else begin
                        logic [CW-1:0] e;
                        e = exp_q[c].pop_front();
                        if (cap_of(c) !== e) begin
                            fails++;
                            $display("FAIL R2 ch%0d stamp: actual=%0h expected=%0h", c, cap_of(c), e);
                        end
                    end
                    last_cap[c] = cap_of(c);
                end
            end
        end
    end

    // driver: called just after a falling edge; stamp = counter seen two edges later
    task automatic drive_pins(logic [NCH-1:0] mask, logic [NCH-1:0] lvl,
                              logic [NCH-1:0] expect_mask, int clr_at,
                              logic [NCH-1:0] clr_mask);
        logic [CW-1:0] v;
        v = cnt;
        for (int c = 0; c < NCH; c++) begin
            if (mask[c]) pin[c] = lvl[c];
            if (expect_mask[c]) exp_q[c].push_back(v + 16'd2);
        end
        for (int i = 1; i <= 6; i++) begin
            @(negedge clk);
            clr = (i == clr_at) ? clr_mask : '0;
        end
        clr = '0;
    endtask

    task automatic clear(logic [NCH-1:0] mask);
        clr = mask;
        @(negedge clk);
        clr = '0;
        @(negedge clk);
    endtask

    initial begin
        #(200000 * 4);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=timeout expected=finish");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        logic [CW-1:0] c0;
        sel = 8'b00_11_10_01;  // ch3 off, ch2 both, ch1 falling, ch0 rising
        en  = 4'b0101;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        chk("R1 caps", cap_val, '0);
        chk("R1 flags", flag, '0);
        chk("R1 ovr", ovr, '0);
        chk("R1 irq", irq, '0);

        // R3 rising on ch0, interrupt enabled
        drive_pins(4'b0001, 4'b0001, 4'b0001, 0, '0);
        chk("R3 flag0", flag[0], 1'b1);
        chk("R10 irq0", irq[0], 1'b1);
        c0 = cap_of(0);
        drive_pins(4'b0001, 4'b0000, 4'b0000, 0, '0);
        chk("R3 fall ignored cap0", cap_of(0), c0);
        chk("R3 fall ignored ovr0", ovr[0], 1'b0);
        chk("R7 flag0 held", flag[0], 1'b1);
        clear(4'b0001);
        chk("R7 flag0 cleared", flag[0], 1'b0);
        chk("R10 irq0 low", irq[0], 1'b0);

        // R4 falling on ch1, interrupt disabled
        drive_pins(4'b0010, 4'b0010, 4'b0000, 0, '0);
        chk("R4 rise ignored flag1", flag[1], 1'b0);
        drive_pins(4'b0010, 4'b0000, 4'b0010, 0, '0);
        chk("R4 flag1", flag[1], 1'b1);
        chk("R10 irq1 masked", irq[1], 1'b0);

        // R5 both edges on ch2, second one overruns
        drive_pins(4'b0100, 4'b0100, 4'b0100, 0, '0);
        chk("R5 flag2", flag[2], 1'b1);
        chk("R9 no ovr yet", ovr[2], 1'b0);
        drive_pins(4'b0100, 4'b0000, 4'b0100, 0, '0);
        chk("R5 flag2 again", flag[2], 1'b1);
        chk("R9 ovr2", ovr[2], 1'b1);

        // R6 disabled ch3
        drive_pins(4'b1000, 4'b1000, 4'b0000, 0, '0);
        drive_pins(4'b1000, 4'b0000, 4'b0000, 0, '0);
        chk("R6 flag3", flag[3], 1'b0);
        chk("R6 cap3", cap_of(3), 16'h0);

        clear(4'b1111);
        chk("R7 all flags cleared", flag, 4'b0000);
        chk("R9 ovr cleared", ovr, 4'b0000);

        // R11 simultaneous events
        drive_pins(4'b0101, 4'b0101, 4'b0101, 0, '0);
        chk("R11 flags", flag, 4'b0101);
        chk("R11 same stamp", cap_of(0), cap_of(2));

        // R8 clear in the same cycle as an event on ch0
        drive_pins(4'b0001, 4'b0000, 4'b0000, 0, '0);
        drive_pins(4'b0001, 4'b0001, 4'b0001, 2, 4'b0001);
        chk("R8 flag0 kept", flag[0], 1'b1);
        chk("R9 clear drops ovr0", ovr[0], 1'b0);

        // R10 enable removed while flag set
        en[0] = 1'b0;
        @(negedge clk);
        chk("R10 flag0 still set", flag[0], 1'b1);
        chk("R10 irq0 gated", irq[0], 1'b0);

        for (int c = 0; c < NCH; c++)
            chk("R2 missing capture", exp_q[c].size(), 0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule